// File: doc/BRIEF.md
# Serial Transmitter with Sixteenth-Bit Stop Control

This block sends characters on an asynchronous serial line. A 16x bit-rate enable, `tick16`, paces it: every bit time on the line lasts sixteen ticks. Software-side logic places a character in a one-entry holding register. The transmitter moves it into a shift register and sends a frame with these parts:

- a low start bit
- 5 to 8 data bits, least significant first
- an optional parity bit
- a high stop period

The stop period is set in sixteenths of a bit.

Two command pulses turn the transmitter on and off. While the transmitter is off, the holding register takes no writes. A character already on the line is always finished. An optional clear-to-send gate holds back the start of each character until `cts` is high. An optional automatic mode drops `rts` once the transmitter has run dry.

Top module: `uart_tx_frac`

## Requirements
- R1: After reset, `txd`=1, `tx_rdy`=0, `tx_emt`=1 and `rts`=0. The transmitter starts out disabled.
- R2: A `cmd_enable` pulse enables the transmitter and a `cmd_disable` pulse disables it. If both pulses come in the same cycle, disable wins. While enabled with an empty holding register, `tx_rdy` is 1 in the cycle after the command.
- R3: A write (`wr_valid`) while disabled is dropped. Enabling afterwards shows `tx_emt`=1 and no start bit follows.
- R4: A frame is one start bit of 16 low ticks, then the data bits least significant first at 16 ticks each. The line idles high. `cfg_char_len` selects the data bits: 00=5, 01=6, 10=7, 11=8.
- R5: `cfg_par_mode` 00 adds a parity bit of 16 ticks. With `cfg_par_odd`=0 the data plus parity have an even count of ones; with `cfg_par_odd`=1 the count is odd. Mode 10 sends no parity bit.
- R6: Modes 01 (forced) and 11 (multidrop address/data flag) send a parity-position bit equal to `cfg_par_odd`.
- R7: For stop codes 0..7 (`cfg_stop_code`) the stop period is 9+code ticks (9/16 to 16/16 bit). For codes 8..15 it is 17+code ticks (25/16 to 32/16 bit).
- R8: With 5-bit characters, stop codes 0..7 last 8 ticks longer. Codes 8..15 are unchanged.
- R9: With `cfg_cts_gate`=1, no character starts while `cts`=0. The start bit begins at the first tick once `cts`=1. With `cfg_cts_gate`=0, `cts` has no effect.
- R10: `cmd_rts_on` sets `rts` and `cmd_rts_off` clears it. With `cfg_auto_rts`=1, `rts` falls at the tick that ends a stop period with the holding register empty. It stays high if another character is waiting.
- R11: A disable during a frame lets that frame finish. A character waiting in the holding register is sent only after re-enabling.
- R12: A character waiting when a stop period ends starts its start bit on the very next tick, with no extra idle time.
- R13: `tx_rdy` is 1 when enabled with an empty holding register. `tx_emt` is 1 when the holding register is empty and no frame is on the line. A write to a full holding register is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | 16x bit-rate enable, one cycle wide |
| cfg_char_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| cfg_par_mode | input | 2 | 00 normal, 01 forced, 10 none, 11 multidrop |
| cfg_par_odd | input | 1 | Parity sense, or forced bit value |
| cfg_stop_code | input | 4 | Stop length code |
| cfg_cts_gate | input | 1 | Wait for `cts` before each start |
| cfg_auto_rts | input | 1 | Drop `rts` when the transmitter empties |
| cmd_enable | input | 1 | Enable pulse |
| cmd_disable | input | 1 | Disable pulse |
| cmd_rts_on | input | 1 | Set `rts` |
| cmd_rts_off | input | 1 | Clear `rts` |
| wr_valid | input | 1 | Write strobe to the holding register |
| wr_data | input | 8 | Character to send |
| cts | input | 1 | Clear-to-send, active high |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Holding register can take a character |
| tx_emt | output | 1 | Holding and shift registers both empty |
| rts | output | 1 | Request-to-send, active high |

## Verification
The bench records the line at every tick and measures each stop period in ticks.

- **Stop arithmetic.** It covers both halves of the stop code table and the 5-bit lengthening. A design that mixed up the two ranges, or lengthened every code for 5-bit characters, would be off by 8 or 16 ticks.
- **Back-to-back frames.** An extra idle tick between frames, or an `rts` drop while a character is still waiting, shows up in the gap between two frames sent back to back.
- **Dropped writes.** Writes while disabled and writes to a full holding register are both sent. A design that accepted either would put an unexpected frame on the line.
- **Disable mid-frame.** A disable during a frame is checked for a cut-short frame and for a held character that leaks out before re-enabling.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int CHAR_W = 8;
  localparam int OS = 16;
  localparam int STOP_W = 6;
  localparam int IDX_W = $clog2(CHAR_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } txf_state_e;

  // Stop length in ticks; lower codes are fractions of one bit, upper codes extend past one bit.
  function automatic logic [STOP_W-1:0] stop_ticks(input logic [3:0] code, input logic five_bit);
    logic [STOP_W-1:0] t;
    t = STOP_W'(code) + (code[3] ? STOP_W'(17) : STOP_W'(9));
    if (five_bit && !code[3]) t = t + STOP_W'(OS / 2);
    return t;
  endfunction

  function automatic logic [IDX_W-1:0] last_index(input logic [1:0] len);
    return IDX_W'(4) + IDX_W'(len);
  endfunction

  function automatic logic parity_bit(input logic [CHAR_W-1:0] d, input logic [1:0] len,
                                      input logic [1:0] mode, input logic odd);
    logic [CHAR_W-1:0] mask;
    mask = {CHAR_W{1'b1}} >> (2'd3 - len);
    if (mode[0]) return odd;
    return (^(d & mask)) ^ odd;
  endfunction
endpackage

// File: rtl/txf_hold.sv
module txf_hold
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              wr_valid,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              take,
  output logic              en,
  output logic              hold_full,
  output logic [CHAR_W-1:0] hold_data,
  output logic              wr_accept
);
  assign wr_accept = wr_valid && en && !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0;
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      if (cmd_disable) en <= 1'b0;
      else if (cmd_enable) en <= 1'b1;
      if (take) hold_full <= 1'b0;
      else if (wr_accept) begin
        hold_full <= 1'b1;
        hold_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/txf_frame.sv
module txf_frame
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_ok,
  input  logic [CHAR_W-1:0] hold_data,
  input  logic [1:0]        cfg_char_len,
  input  logic [1:0]        cfg_par_mode,
  input  logic              cfg_par_odd,
  input  logic [3:0]        cfg_stop_code,
  output logic              txd,
  output logic              busy,
  output logic              launch,
  output logic              frame_done
);
  txf_state_e        state;
  logic [STOP_W-1:0] tcnt;
  logic [STOP_W-1:0] stop_len;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  last_idx;
  logic [CHAR_W-1:0] shreg;
  logic              par_en;
  logic              par_val;
  logic              phase_end;

  assign phase_end  = (tcnt == STOP_W'(OS - 1));
  assign frame_done = tick && (state == ST_STOP) && (tcnt == stop_len - STOP_W'(1));
  assign launch     = tick && start_ok && ((state == ST_IDLE) || frame_done);
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tcnt     <= '0;
      stop_len <= STOP_W'(16);
      bit_idx  <= '0;
      last_idx <= '0;
      shreg    <= '0;
      par_en   <= 1'b0;
      par_val  <= 1'b0;
    end else if (launch) begin
      state    <= ST_START;
      tcnt     <= '0;
      bit_idx  <= '0;
      shreg    <= hold_data;
      last_idx <= last_index(cfg_char_len);
      par_en   <= (cfg_par_mode != 2'b10);
      par_val  <= parity_bit(hold_data, cfg_char_len, cfg_par_mode, cfg_par_odd);
      stop_len <= stop_ticks(cfg_stop_code, cfg_char_len == 2'b00);
    end else if (tick) begin
      case (state)
        ST_IDLE: tcnt <= '0;
        ST_START: begin
          if (phase_end) begin
            state <= ST_DATA;
            tcnt  <= '0;
          end else tcnt <= tcnt + STOP_W'(1);
        end
        ST_DATA: begin
          if (phase_end) begin
            tcnt <= '0;
            if (bit_idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
            else begin
              bit_idx <= bit_idx + IDX_W'(1);
              shreg   <= shreg >> 1;
            end
          end else tcnt <= tcnt + STOP_W'(1);
        end
        ST_PAR: begin
          if (phase_end) begin
            state <= ST_STOP;
            tcnt  <= '0;
          end else tcnt <= tcnt + STOP_W'(1);
        end
        ST_STOP: begin
          if (frame_done) begin
            state <= ST_IDLE;
            tcnt  <= '0;
          end else tcnt <= tcnt + STOP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      ST_PAR:   txd = par_val;
      default:  txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/txf_rts.sv
module txf_rts (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_rts_on,
  input  logic cmd_rts_off,
  input  logic auto_en,
  input  logic frame_done,
  input  logic hold_full,
  output logic rts,
  output logic rts_release
);
  assign rts_release = auto_en && frame_done && !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) rts <= 1'b0;
    else if (cmd_rts_on) rts <= 1'b1;
    else if (cmd_rts_off || rts_release) rts <= 1'b0;
  end
endmodule

// File: rtl/uart_tx_frac.sv
module uart_tx_frac
  import txf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic [1:0]  cfg_char_len,
  input  logic [1:0]  cfg_par_mode,
  input  logic        cfg_par_odd,
  input  logic [3:0]  cfg_stop_code,
  input  logic        cfg_cts_gate,
  input  logic        cfg_auto_rts,
  input  logic        cmd_enable,
  input  logic        cmd_disable,
  input  logic        cmd_rts_on,
  input  logic        cmd_rts_off,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  input  logic        cts,
  output logic        txd,
  output logic        tx_rdy,
  output logic        tx_emt,
  output logic        rts
);
  logic              en;
  logic              hold_full;
  logic [CHAR_W-1:0] hold_data;
  logic              wr_accept;
  logic              busy;
  logic              launch;
  logic              frame_done;
  logic              start_ok;
  logic              rts_release;

  assign start_ok = en && hold_full && (!cfg_cts_gate || cts);
  assign tx_rdy   = en && !hold_full;
  assign tx_emt   = !hold_full && !busy;

  txf_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .wr_valid(wr_valid), .wr_data(wr_data), .take(launch), .en(en),
    .hold_full(hold_full), .hold_data(hold_data), .wr_accept(wr_accept)
  );

  txf_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .start_ok(start_ok), .hold_data(hold_data),
    .cfg_char_len(cfg_char_len), .cfg_par_mode(cfg_par_mode), .cfg_par_odd(cfg_par_odd),
    .cfg_stop_code(cfg_stop_code), .txd(txd), .busy(busy), .launch(launch),
    .frame_done(frame_done)
  );

  txf_rts u_rts (
    .clk(clk), .rst_n(rst_n), .cmd_rts_on(cmd_rts_on), .cmd_rts_off(cmd_rts_off),
    .auto_en(cfg_auto_rts), .frame_done(frame_done), .hold_full(hold_full), .rts(rts),
    .rts_release(rts_release)
  );
endmodule

// File: rtl/txf_chk.sv
module txf_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_cts_gate,
  input logic cfg_auto_rts,
  input logic cts,
  input logic wr_valid,
  input logic cmd_disable,
  input logic cmd_rts_on,
  input logic txd,
  input logic tx_emt,
  input logic tx_rdy,
  input logic rts,
  input logic en,
  input logic hold_full,
  input logic busy,
  input logic launch,
  input logic frame_done,
  input logic wr_accept
);
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> txd);
  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n) launch |=> !txd);
  p_write_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && wr_valid && !hold_full) |=> !hold_full);
  p_disable_drops_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n) cmd_disable |=> !tx_rdy);
  p_cts_gate_r9: assert property (@(posedge clk) disable iff (!rst_n) launch |-> (!cfg_cts_gate || cts));
  p_rts_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && cfg_auto_rts && !hold_full && !cmd_rts_on) |=> !rts);
  p_launch_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n) launch |-> en);
  p_busy_not_empty_r13: assert property (@(posedge clk) disable iff (!rst_n) launch |=> !tx_emt);
  p_full_write_dropped_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !launch) |-> !wr_accept);
endmodule

bind uart_tx_frac txf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cts_gate(cfg_cts_gate), .cfg_auto_rts(cfg_auto_rts),
  .cts(cts), .wr_valid(wr_valid), .cmd_disable(cmd_disable), .cmd_rts_on(cmd_rts_on),
  .txd(txd), .tx_emt(tx_emt), .tx_rdy(tx_rdy), .rts(rts), .en(en), .hold_full(hold_full),
  .busy(busy), .launch(launch), .frame_done(frame_done), .wr_accept(wr_accept)
);

// File: tb/tb_uart_tx_frac.sv
module tb_uart_tx_frac;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic [1:0] cfg_char_len = 2'b11;
  logic [1:0] cfg_par_mode = 2'b10;
  logic cfg_par_odd = 1'b0;
  logic [3:0] cfg_stop_code = 4'd7;
  logic cfg_cts_gate = 1'b0, cfg_auto_rts = 1'b0;
  logic cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_rts_on = 1'b0, cmd_rts_off = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic cts = 1'b0;
  logic txd, tx_rdy, tx_emt, rts;

  int errors = 0, checks = 0;
  bit finished = 0;
  localparam int RECMAX = 16384;
  bit rec_txd [RECMAX];
  bit rec_emt [RECMAX];
  bit rec_rts [RECMAX];
  int rec_n = 0;
  int tdiv = 0;

  always #10 clk = ~clk;

  uart_tx_frac dut (.*);

  always @(negedge clk) begin
    if (tick16 && rec_n < RECMAX) begin
      rec_txd[rec_n] = txd; rec_emt[rec_n] = tx_emt; rec_rts[rec_n] = rts;
      rec_n = rec_n + 1;
    end
    tick16 = (tdiv == 3);
    tdiv = (tdiv + 1) % 4;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    int tgt = rec_n + n;
    while (rec_n < tgt) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmd_enable = 1; 1: cmd_disable = 1; 2: cmd_rts_on = 1; 3: cmd_rts_off = 1;
      default: begin cmd_enable = 1; cmd_disable = 1; end
    endcase
    @(negedge clk);
    cmd_enable = 0; cmd_disable = 0; cmd_rts_on = 0; cmd_rts_off = 0;
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic wait_rdy();
    @(negedge clk);
    while (!tx_rdy) @(negedge clk);
  endtask

  function automatic int zeros_from(input int from);
    int z = 0;
    for (int i = from; i < rec_n; i++) if (!rec_txd[i]) z++;
    return z;
  endfunction

  // finds the next frame from index 'from'; stop_end is the first index after the stop period
  task automatic decode(input int from, input int nb, input bit has_par, output int s,
                        output int data, output bit pb, output int stop_end);
    int i = from;
    int b;
    data = 0; pb = 0; s = -1; stop_end = -1;
    while (i < rec_n && rec_txd[i]) i++;
    if (i + 16 * (nb + 2) >= rec_n) return;
    s = i;
    for (int k = 0; k < 16; k++) if (rec_txd[s + k]) s = -2;
    if (s < 0) return;
    for (int k = 0; k < nb; k++) data = data | (int'(rec_txd[s + 16 + 16 * k + 8]) << k);
    if (has_par) pb = rec_txd[s + 16 + 16 * nb + 8];
    b = s + 16 + 16 * nb + (has_par ? 16 : 0);
    i = b;
    while (i < rec_n && rec_txd[i] && !rec_emt[i]) i++;
    stop_end = i;
  endtask

  function automatic int stop_expect(input int code, input int nb);
    int sixteenths = (code < 8) ? 16 - (7 - code) : 32 - (15 - code);
    if (nb == 5 && code < 8) sixteenths += 8;
    return sixteenths;
  endfunction

  function automatic bit par_expect(input logic [7:0] d, input int nb, input logic [1:0] pm, input bit odd);
    int ones = 0;
    if (pm == 2'b01 || pm == 2'b11) return odd;
    for (int k = 0; k < nb; k++) ones += d[k];
    return bit'(ones % 2) ^ odd;
  endfunction

  task automatic one_frame(input logic [7:0] d, input logic [1:0] len, input logic [1:0] pm,
                           input bit odd, input int code, input string preq, input string sreq);
    int nb = 5 + len;
    int base, s, got, se;
    bit pb;
    bit hp = (pm != 2'b10);
    logic [7:0] mask = 8'hFF >> (8 - nb);
    @(negedge clk);
    cfg_char_len = len; cfg_par_mode = pm; cfg_par_odd = odd; cfg_stop_code = 4'(code);
    base = rec_n;
    write(d);
    ticks(16 * (nb + 3) + 48);
    decode(base, nb, hp, s, got, pb, se);
    chk(s >= 0 && got == int'(d & mask), "R4", "data bits", got, int'(d & mask));
    if (hp) chk(pb == par_expect(d, nb, pm, odd), preq, "parity bit", pb, par_expect(d, nb, pm, odd));
    chk(se - (s + 16 * (nb + 1) + (hp ? 16 : 0)) == stop_expect(code, nb), sreq, "stop ticks",
        se - (s + 16 * (nb + 1) + (hp ? 16 : 0)), stop_expect(code, nb));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R1", "txd after reset", txd, 1);
    chk(tx_rdy == 0, "R1", "tx_rdy after reset", tx_rdy, 0);
    chk(tx_emt == 1, "R1", "tx_emt after reset", tx_emt, 1);
    chk(rts == 0, "R1", "rts after reset", rts, 0);
  endtask

  task automatic t_refuse_and_enable();
    int base;
    write(8'h55);
    pulse(0);
    chk(tx_rdy == 1, "R2", "tx_rdy after enable", tx_rdy, 1);
    chk(tx_emt == 1, "R3", "tx_emt after disabled write", tx_emt, 1);
    base = rec_n;
    ticks(120);
    chk(zeros_from(base) == 0, "R3", "low ticks after disabled write", zeros_from(base), 0);
    pulse(4);
    chk(tx_rdy == 0, "R2", "tx_rdy after enable+disable together", tx_rdy, 0);
    pulse(0);
    chk(tx_rdy == 1, "R2", "tx_rdy after re-enable", tx_rdy, 1);
  endtask

  task automatic t_frames();
    one_frame(8'hA6, 2'b11, 2'b10, 0, 7, "R5", "R7");
    one_frame(8'h1B, 2'b00, 2'b00, 0, 0, "R5", "R8");
    one_frame(8'h0E, 2'b00, 2'b10, 0, 8, "R5", "R8");
    one_frame(8'h35, 2'b10, 2'b00, 1, 3, "R5", "R7");
    one_frame(8'h2C, 2'b01, 2'b01, 1, 15, "R6", "R7");
    one_frame(8'hF0, 2'b11, 2'b11, 0, 5, "R6", "R7");
  endtask

  task automatic t_back_to_back();
    int base, s1, s2, d1, d2, e1, e2;
    bit pb;
    @(negedge clk); cfg_char_len = 2'b11; cfg_par_mode = 2'b10; cfg_stop_code = 4'd15;
    base = rec_n;
    write(8'hC3); wait_rdy(); write(8'h81);
    ticks(480);
    decode(base, 8, 0, s1, d1, pb, e1);
    decode(e1, 8, 0, s2, d2, pb, e2);
    chk(s1 >= 0 && d1 == 8'hC3, "R12", "first data", d1, 8'hC3);
    chk(e1 - (s1 + 144) == 32, "R12", "gap before second start", e1 - (s1 + 144), 32);
    chk(s2 == e1 && d2 == 8'h81, "R12", "second data", d2, 8'h81);
    chk(e2 - (s2 + 144) == 32, "R7", "second stop ticks", e2 - (s2 + 144), 32);
  endtask

  task automatic t_cts();
    int base, s, d, e;
    bit pb;
    @(negedge clk); cfg_stop_code = 4'd7; cfg_cts_gate = 1; cts = 0;
    base = rec_n;
    write(8'h11); write(8'h22);
    chk(tx_rdy == 0 && tx_emt == 0, "R13", "status with held char", {tx_rdy, tx_emt}, 0);
    ticks(60);
    chk(zeros_from(base) == 0, "R9", "low ticks while cts low", zeros_from(base), 0);
    @(negedge clk); cts = 1;
    base = rec_n;
    ticks(260);
    decode(base, 8, 0, s, d, pb, e);
    chk(s >= base && s <= base + 1, "R9", "start delay after cts", s - base, 0);
    chk(d == 8'h11, "R13", "held char (full write dropped)", d, 8'h11);
    chk(zeros_from(e) == 0 && tx_emt == 1, "R13", "no second frame", zeros_from(e), 0);
    @(negedge clk); cfg_cts_gate = 0; cts = 0;
    one_frame(8'h5A, 2'b11, 2'b10, 0, 7, "R9", "R9");
  endtask

  task automatic t_rts();
    int base, s1, s2, d, e1, e2;
    bit pb;
    @(negedge clk); cfg_auto_rts = 1;
    pulse(2);
    chk(rts == 1, "R10", "rts after set", rts, 1);
    base = rec_n;
    write(8'h96); wait_rdy(); write(8'h69);
    ticks(420);
    decode(base, 8, 0, s1, d, pb, e1);
    chk(e1 < rec_n && rec_rts[e1] == 1, "R10", "rts kept with char waiting", rec_rts[e1], 1);
    decode(e1, 8, 0, s2, d, pb, e2);
    chk(e2 < rec_n && rec_rts[e2] == 0 && rec_rts[e2 - 1] == 1, "R10", "rts drop at stop end",
        rec_rts[e2], 0);
    @(negedge clk); cfg_auto_rts = 0;
    pulse(2);
    one_frame(8'h3D, 2'b11, 2'b10, 0, 7, "R10", "R7");
    chk(rts == 1, "R10", "rts held without auto", rts, 1);
    pulse(3);
    chk(rts == 0, "R10", "rts after clear", rts, 0);
  endtask

  task automatic t_disable();
    int base, s, d, e;
    bit pb;
    base = rec_n;
    write(8'hA5); wait_rdy(); write(8'h3C);
    pulse(1);
    ticks(400);
    decode(base, 8, 0, s, d, pb, e);
    chk(s >= 0 && d == 8'hA5, "R11", "frame finished after disable", d, 8'hA5);
    chk(zeros_from(s + 160) == 0, "R11", "held char not sent", zeros_from(s + 160), 0);
    chk(tx_emt == 0 && tx_rdy == 0, "R11", "status while disabled and held", {tx_rdy, tx_emt}, 0);
    base = rec_n;
    pulse(0);
    ticks(260);
    decode(base, 8, 0, s, d, pb, e);
    chk(s >= 0 && d == 8'h3C, "R11", "held char after re-enable", d, 8'h3C);
  endtask

  initial begin
    t_reset();
    t_refuse_and_enable();
    t_frames();
    t_back_to_back();
    t_cts();
    t_rts();
    t_disable();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule